// File: doc/BRIEF.md
# Hiccup Overload Restart Sequencer

This block supervises a current-mode PWM power stage. It watches a per-cycle current-limit flag and a cycle-boundary strobe. Each cycle that ends current-limited adds a fixed step to a restart accumulator, and each clean cycle removes the same step, with zero as the floor. When the accumulator would reach its threshold, or when an external force request arrives, the block starts a hiccup restart. It clears both the accumulator and the soft-start ramp to zero. The ramp then climbs again at one-fiftieth of its normal rate, and the normal rate returns when the PWM reports its first output pulse.

The soft-start ramp is a saturating counter that stands in for the soft-start capacitor voltage. The ramp value is an output, and the downstream comparator uses it to clamp its command. Full scale is 4000 codes, so 1120 codes equals 1.4 V and 2000 accumulator codes equals 2.5 V. Output pulses are permitted only while the ramp is above the offset level. In standby the ramp stops charging and falls at the normal rate. This is a soft-stop: the duty cycle tapers to zero.

A two-bit mode input selects the overload policy:
- delayed hiccup (code 0);
- cycle-by-cycle limiting only, with the accumulator held at zero (code 1);
- immediate hiccup on the first limited cycle (code 2).

Code 3 behaves as code 0. All state is cleared by a synchronous active-high reset.

Top module: `hiccup_restart_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `ss_ramp`, `restart_level` and `hiccup_active` become zero, and `pulse_en` is low.
- R2: At each `cyc_strobe` edge in mode 0, a limited cycle raises `restart_level` by ACC_STEP (250). A clean cycle lowers it by ACC_STEP, but never below zero. Between strobes `restart_level` holds.
- R3: An `ilim_hit` pulse at any edge since the previous strobe marks the cycle as limited, even if `ilim_hit` is low at the strobe itself.
- R4: When a limited strobe would bring `restart_level` to ACC_THRESH (2000) or above, `restart_level` and `ss_ramp` are both zero after that edge, and `hiccup_active` is high.
- R5: `pulse_en` is high exactly when `ss_ramp` exceeds RAMP_OFFSET (1120).
- R6: While `hiccup_active` is high and `standby` is low, `ss_ramp` grows by RATE_NORM (8) once every SLOW_DIV (50) clocks, counted from the restart edge.
- R7: Outside a restart, and after the edge at which `first_pulse` is seen while `hiccup_active` is high, `ss_ramp` grows by RATE_NORM every clock. `hiccup_active` is low after that edge.
- R8: In mode 1, `restart_level` stays zero and no restart occurs, however many cycles are limited.
- R9: `ss_ramp` saturates at RAMP_MAX (4000).
- R10: While `standby` is high, `ss_ramp` falls by RATE_NORM per clock and stops at zero.
- R11: In mode 2, the first limited strobe starts a restart, with the same effects as R4.
- R12: A `force_restart` pulse starts a restart in any mode, with the same effects as R4.
- R13: If a restart and `first_pulse` arrive at the same edge, the restart wins and `hiccup_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | One-clock strobe at each PWM cycle boundary |
| ilim_hit | input | 1 | Current-limit event in the present PWM cycle |
| first_pulse | input | 1 | PWM issued an output pulse |
| force_restart | input | 1 | External request to start a restart now |
| standby | input | 1 | Request soft-stop: discharge the ramp |
| hiccup_mode | input | 2 | 0 delayed hiccup, 1 cycle-by-cycle only, 2 immediate hiccup, 3 same as 0 |
| ss_ramp | output | RAMP_W | Soft-start ramp value clamping the PWM command |
| restart_level | output | ACC_W | Restart accumulator value |
| pulse_en | output | 1 | Ramp is above the offset; pulses are permitted |
| hiccup_active | output | 1 | High from a restart until the first pulse after it |

## Verification
Some properties are checked on every cycle:
- the accumulator stays below its threshold;
- the accumulator holds between strobes;
- both counters read zero the edge after a restart;
- the ramp never passes its ceiling and never rises in standby;
- the restart flag sets, clears and holds as its inputs dictate.

Other behaviours need the bench's scenarios, since they depend on exact counts over many edges:
- the one-in-fifty slow growth after a restart;
- the return to full rate on the first pulse;
- the pulse-permit boundary at the offset;
- the latching of a mid-cycle limit event;
- the three mode policies;
- the step-by-step soft-stop down to zero.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [1:0] {
    HM_DELAYED   = 2'd0,
    HM_CBC_ONLY  = 2'd1,
    HM_IMMEDIATE = 2'd2,
    HM_RESERVED  = 2'd3
  } hic_mode_e;
endpackage

// File: rtl/hrs_accum.sv
module hrs_accum
  import hrs_pkg::*;
#(
  parameter int ACC_W      = 12,
  parameter int ACC_STEP   = 250,
  parameter int ACC_THRESH = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_strobe,
  input  logic             ilim_hit,
  input  logic             clr,
  input  hic_mode_e        mode,
  output logic             trip,
  output logic [ACC_W-1:0] acc_q
);
  localparam logic [ACC_W:0]   THRESH_E = (ACC_W+1)'(ACC_THRESH);
  localparam logic [ACC_W:0]   STEP_E   = (ACC_W+1)'(ACC_STEP);
  localparam logic [ACC_W-1:0] STEP_N   = ACC_W'(ACC_STEP);

  logic             seen_q;
  logic             limited;
  logic [ACC_W:0]   acc_up;
  logic [ACC_W-1:0] acc_dn;
  logic [ACC_W-1:0] acc_d;

  // a limit event anywhere in the cycle counts at the boundary
  assign limited = seen_q | ilim_hit;
  assign acc_up  = {1'b0, acc_q} + STEP_E;
  assign acc_dn  = (acc_q > STEP_N) ? (acc_q - STEP_N) : '0;

  always_comb begin
    trip = 1'b0;
    if (cyc_strobe && limited) begin
      unique case (mode)
        HM_CBC_ONLY:  trip = 1'b0;
        HM_IMMEDIATE: trip = 1'b1;
        default:      trip = (acc_up >= THRESH_E);
      endcase
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (cyc_strobe) begin
      if (mode == HM_CBC_ONLY) acc_d = '0;
      else if (limited)        acc_d = acc_up[ACC_W-1:0];
      else                     acc_d = acc_dn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      if (cyc_strobe)    seen_q <= 1'b0;
      else if (ilim_hit) seen_q <= 1'b1;
    end
  end

  // R2: the level never rests at or above the threshold
  a_r2_below_thresh: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc_q} < THRESH_E);
  // R2: the level only moves on a cycle boundary or a restart
  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!cyc_strobe && !clr) |=> $stable(acc_q));
  // R4: a restart empties the accumulator
  a_r4_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));
  // R8: cycle-by-cycle-only mode keeps the level at zero
  a_r8_cbc_zero: assert property (@(posedge clk) disable iff (rst)
    (cyc_strobe && mode == HM_CBC_ONLY) |=> (acc_q == '0));
endmodule

// File: rtl/hrs_ss_ramp.sv
module hrs_ss_ramp #(
  parameter int RAMP_W    = 12,
  parameter int RAMP_MAX  = 4000,
  parameter int RATE_NORM = 8,
  parameter int SLOW_DIV  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              slow,
  input  logic              standby,
  output logic [RAMP_W-1:0] ramp_q
);
  localparam logic [RAMP_W:0]   MAX_E  = (RAMP_W+1)'(RAMP_MAX);
  localparam logic [RAMP_W:0]   RATE_E = (RAMP_W+1)'(RATE_NORM);
  localparam logic [RAMP_W-1:0] MAX_N  = RAMP_W'(RAMP_MAX);
  localparam logic [RAMP_W-1:0] RATE_N = RAMP_W'(RATE_NORM);

  logic              grow_tick;
  logic [RAMP_W:0]   sum_e;
  logic [RAMP_W-1:0] up_v;
  logic [RAMP_W-1:0] dn_v;

  generate
    if (SLOW_DIV > 1) begin : g_pace
      localparam int CW = $clog2(SLOW_DIV);
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == CW'(SLOW_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clr || !slow) cnt_q <= '0;
        else if (wrap)           cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end
      assign grow_tick = !slow || wrap;
    end else begin : g_nopace
      assign grow_tick = 1'b1;
    end
  endgenerate

  assign sum_e = {1'b0, ramp_q} + RATE_E;
  assign up_v  = (sum_e > MAX_E) ? MAX_N : sum_e[RAMP_W-1:0];
  assign dn_v  = (ramp_q > RATE_N) ? (ramp_q - RATE_N) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr)     ramp_q <= '0;
    else if (standby)   ramp_q <= dn_v;
    else if (grow_tick) ramp_q <= up_v;
  end

  // R9: the ramp never exceeds its ceiling
  a_r9_ceiling: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ramp_q} <= MAX_E);
  // R4: a restart empties the ramp
  a_r4_ramp_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ramp_q == '0));
  // R10: soft-stop never raises the ramp
  a_r10_no_rise: assert property (@(posedge clk) disable iff (rst)
    (standby && !clr) |=> (ramp_q <= $past(ramp_q)));
endmodule

// File: rtl/hrs_restart_ctl.sv
module hrs_restart_ctl (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic force_restart,
  input  logic first_pulse,
  output logic restart,
  output logic hact_q
);
  assign restart = trip | force_restart;

  always_ff @(posedge clk) begin
    if (rst)              hact_q <= 1'b0;
    else if (restart)     hact_q <= 1'b1;
    else if (first_pulse) hact_q <= 1'b0;
  end

  // R12 R13: any restart leaves the flag set
  a_r13_restart_sets: assert property (@(posedge clk) disable iff (rst)
    restart |=> hact_q);
  // R7: the first pulse ends the slow phase
  a_r7_pulse_clears: assert property (@(posedge clk) disable iff (rst)
    (!restart && first_pulse) |=> !hact_q);
  // R7: the flag holds otherwise
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (!restart && !first_pulse) |=> $stable(hact_q));
endmodule

// File: rtl/hiccup_restart_seq.sv
module hiccup_restart_seq
  import hrs_pkg::*;
#(
  parameter int RAMP_W      = 12,
  parameter int RAMP_MAX    = 4000,
  parameter int RAMP_OFFSET = 1120,
  parameter int RATE_NORM   = 8,
  parameter int SLOW_DIV    = 50,
  parameter int ACC_W       = 12,
  parameter int ACC_STEP    = 250,
  parameter int ACC_THRESH  = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_strobe,
  input  logic              ilim_hit,
  input  logic              first_pulse,
  input  logic              force_restart,
  input  logic              standby,
  input  logic [1:0]        hiccup_mode,
  output logic [RAMP_W-1:0] ss_ramp,
  output logic [ACC_W-1:0]  restart_level,
  output logic              pulse_en,
  output logic              hiccup_active
);
  localparam logic [RAMP_W-1:0] OFFSET_N = RAMP_W'(RAMP_OFFSET);

  hic_mode_e mode;
  logic      trip;
  logic      restart;

  assign mode = hic_mode_e'(hiccup_mode);

  hrs_accum #(
    .ACC_W(ACC_W), .ACC_STEP(ACC_STEP), .ACC_THRESH(ACC_THRESH)
  ) u_accum (
    .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .ilim_hit(ilim_hit),
    .clr(restart), .mode(mode), .trip(trip), .acc_q(restart_level)
  );

  hrs_restart_ctl u_ctl (
    .clk(clk), .rst(rst), .trip(trip), .force_restart(force_restart),
    .first_pulse(first_pulse), .restart(restart), .hact_q(hiccup_active)
  );

  hrs_ss_ramp #(
    .RAMP_W(RAMP_W), .RAMP_MAX(RAMP_MAX), .RATE_NORM(RATE_NORM),
    .SLOW_DIV(SLOW_DIV)
  ) u_ramp (
    .clk(clk), .rst(rst), .clr(restart), .slow(hiccup_active),
    .standby(standby), .ramp_q(ss_ramp)
  );

  assign pulse_en = (ss_ramp > OFFSET_N);

  // R12: a force request is never ignored
  a_r12_force_restart: assert property (@(posedge clk) disable iff (rst)
    force_restart |=> (hiccup_active && ss_ramp == '0));
endmodule

// File: tb/test_hiccup_restart_seq.sv
`timescale 1ns/1ps
module test_hiccup_restart_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        cyc_strobe, ilim_hit, first_pulse, force_restart, standby;
  logic [1:0]  hiccup_mode;
  logic [11:0] ss_ramp;
  logic [11:0] restart_level;
  logic        pulse_en, hiccup_active;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    string tag;
    int    ramp;
    int    acc;
    int    hact;
    int    pen;
  } exp_t;
  exp_t exq[$];

  always #2.5 clk = ~clk;

  hiccup_restart_seq i_hiccup_restart_seq (
    .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .ilim_hit(ilim_hit),
    .first_pulse(first_pulse), .force_restart(force_restart),
    .standby(standby), .hiccup_mode(hiccup_mode), .ss_ramp(ss_ramp),
    .restart_level(restart_level), .pulse_en(pulse_en),
    .hiccup_active(hiccup_active)
  );

  task automatic cmp(string tag, string what, int act, int expv);
    if (expv < 0) return;
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      cmp(e.tag, "ss_ramp", int'(ss_ramp), e.ramp);
      cmp(e.tag, "restart_level", int'(restart_level), e.acc);
      cmp(e.tag, "hiccup_active", int'(hiccup_active), e.hact);
      cmp(e.tag, "pulse_en", int'(pulse_en), e.pen);
    end
  end

  task automatic expect_now(string tag, int r, int a, int h, int p);
    exp_t e;
    e.tag = tag; e.ramp = r; e.acc = a; e.hact = h; e.pen = p;
    exq.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(bit lim);
    cyc_strobe = 1'b1; ilim_hit = lim;
    step(1);
    cyc_strobe = 1'b0; ilim_hit = 1'b0;
  endtask

  task automatic pulse_first();
    first_pulse = 1'b1; step(1); first_pulse = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base;
    rst = 1'b1; cyc_strobe = 0; ilim_hit = 0; first_pulse = 0;
    force_restart = 0; standby = 0; hiccup_mode = 2'd0;
    step(3);
    expect_now("R1 reset", 0, 0, 0, 0);
    rst = 1'b0;
    // R7 normal rate, R5 offset boundary, R9 saturation
    step(140);  expect_now("R5 at offset", 1120, 0, 0, 0);
    step(1);    expect_now("R5 above offset", 1128, 0, 0, 1);
    step(400);  expect_now("R9 saturate", 4000, 0, 0, 1);
    // R2 accumulator up, down and floor
    repeat (3) strobe(1);
    expect_now("R2 climb", 4000, 750, 0, 1);
    strobe(0);  expect_now("R2 drain", -1, 500, 0, -1);
    step(4);    expect_now("R2 hold", -1, 500, 0, -1);
    repeat (3) strobe(0);
    expect_now("R2 floor", -1, 0, 0, -1);
    // R3 mid-cycle event latched
    ilim_hit = 1'b1; step(1); ilim_hit = 1'b0;
    step(2);
    strobe(0);  expect_now("R3 latched", -1, 250, 0, -1);
    strobe(0);  expect_now("R3 cleared", -1, 0, 0, -1);
    // R4 threshold crossing
    repeat (7) strobe(1);
    expect_now("R4 below", 4000, 1750, 0, 1);
    strobe(1);  expect_now("R4 trip", 0, 0, 1, 0);
    // R6 slow growth
    step(49);   expect_now("R6 slow wait", 0, 0, 1, 0);
    step(1);    expect_now("R6 slow tick", 8, 0, 1, 0);
    step(450);  expect_now("R6 slow ten", 80, 0, 1, 0);
    // R7 first pulse restores the normal rate
    pulse_first();
    expect_now("R7 flag off", 80, 0, 0, 0);
    step(5);    expect_now("R7 normal rate", 120, 0, 0, 0);
    // R10 soft-stop
    standby = 1'b1;
    step(5);    expect_now("R10 discharge", 80, 0, 0, 0);
    step(20);   expect_now("R10 floor", 0, 0, 0, 0);
    standby = 1'b0;
    // R8 cycle-by-cycle only
    hiccup_mode = 2'd1;
    repeat (12) strobe(1);
    expect_now("R8 no restart", -1, 0, 0, -1);
    base = int'(ss_ramp);
    step(3);    expect_now("R8 ramp runs", base + 24, 0, 0, -1);
    // R11 immediate hiccup
    hiccup_mode = 2'd2;
    strobe(1);  expect_now("R11 immediate", 0, 0, 1, 0);
    pulse_first();
    expect_now("R11 recover", -1, 0, 0, -1);
    // R12 force restart
    hiccup_mode = 2'd0;
    step(2);
    strobe(1); strobe(1);
    expect_now("R12 pre", -1, 500, 0, -1);
    force_restart = 1'b1; step(1); force_restart = 1'b0;
    expect_now("R12 forced", 0, 0, 1, 0);
    pulse_first();
    expect_now("R12 recover", -1, 0, 0, -1);
    // R13 restart beats first pulse
    step(3);
    force_restart = 1'b1; first_pulse = 1'b1;
    step(1);
    force_restart = 1'b0; first_pulse = 1'b0;
    expect_now("R13 priority", 0, 0, 1, 0);
    // R1 reset mid-run
    rst = 1'b1; step(1); rst = 1'b0;
    expect_now("R1 reset again", 0, 0, 0, 0);
    @(negedge clk); #1;
    finish_run();
  end
endmodule